// File: doc/BRIEF.md
# Clock-Gated Pipeline Error Recovery Controller

This controller sits beside a short in-order pipeline whose speculative stage registers each keep a shadow copy and raise a per-stage timing-error flag. The controller merges every flag into one restore request. The first error seen during normal running starts a recovery cycle. In that cycle the global advance enable is held low, so no stage register moves forward. Restore is also held high, so every speculative register reloads its shadow value and recomputes. Any value already forwarded from a bad stage is therefore replaced before the pipeline moves on. The failing instruction is never fetched or executed again.

Clock gating is done with a synchronous enable, not with a gated clock net. Each error costs exactly one cycle. If errors arrive on every cycle, the pipeline still advances on every second cycle. Errors raised while a recovery is in progress are ignored, because the shadow copies are being held steady at that time. A saturating counter reports how many recovery cycles have been taken. Downstream, the last speculative register must be followed by at least two non-speculative stages before writeback. With non-speculative memory access, this means one extra stabilize stage. That rule belongs to the pipeline that uses the block.

Top module: `pipe_recov_ctrl`

## Requirements
- R1: After reset is released, adv_en_o is 1, restore_o is 0 and stall_cnt_o is 0.
- R2: If any bit of err_i is 1 at a clock edge while restore_o is 0, then restore_o is 1 and adv_en_o is 0 for the next cycle. This holds whichever bit (stage index) is set.
- R3: A recovery lasts exactly one cycle. restore_o is never 1 on two consecutive cycles.
- R4: err_i bits seen at an edge while restore_o is 1 have no effect. restore_o returns to 0 and stall_cnt_o does not change.
- R5: With err_i nonzero on every cycle, adv_en_o is 1 on exactly every second cycle (half rate).
- R6: stall_cnt_o rises by exactly one at the same edge where restore_o rises.
- R7: stall_cnt_o saturates at 2^CNT_W-1 (255 by default) and stays there while further recoveries occur.
- R8: Several err_i bits set at the same edge start a single recovery and add one to stall_cnt_o.
- R9: adv_en_o is always the complement of restore_o.
- R10: While err_i is 0 and no recovery is pending, adv_en_o stays 1 and stall_cnt_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized internally |
| err_i | input | NUM_STAGES | Timing-error flag from each speculative stage register, bit i for stage i |
| adv_en_o | output | 1 | Global advance enable for all stage registers; 0 during a recovery cycle |
| restore_o | output | 1 | Tells the speculative registers to reload from their shadow copies |
| stall_cnt_o | output | CNT_W | Saturating count of recovery cycles taken |

## Verification
The bench looks for an error raised during a recovery cycle. A design that does not mask it would stretch the stall or chain a second restore and double-count. Errors held on every cycle must give strict alternation. A design that re-triggers straight away would freeze the pipeline, and one that never re-arms would lose errors. Several flags at the same edge must count once, not once per stage. The counter is driven past its top value, where a design without saturation would wrap to zero. A reset in the middle of a run must bring all outputs back to their idle values.

// File: rtl/pipe_recov_pkg.sv
package pipe_recov_pkg;
  typedef enum logic {
    ST_RUN     = 1'b0,
    ST_RESTORE = 1'b1
  } rec_state_e;
endpackage

// File: rtl/recov_rst_sync.sv
module recov_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/recov_err_merge.sv
module recov_err_merge #(
  parameter int NUM_STAGES = 3
) (
  input  logic [NUM_STAGES-1:0] err_i,
  output logic                  any_err_o
);
  logic [NUM_STAGES:0] chain;
  assign chain[0] = 1'b0;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_or
    assign chain[g+1] = chain[g] | err_i[g];
  end

  assign any_err_o = chain[NUM_STAGES];
endmodule

// File: rtl/recov_fsm.sv
module recov_fsm
  import pipe_recov_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic any_err_i,
  output logic restore_o,
  output logic start_o
);
  rec_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    start_o = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (any_err_i) begin
          state_d = ST_RESTORE;
          start_o = 1'b1;
        end
      end
      ST_RESTORE: state_d = ST_RUN;
      default:    state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign restore_o = (state_q == ST_RESTORE);
endmodule

// File: rtl/recov_sat_cnt.sv
module recov_sat_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = inc_i && (cnt_q != CNT_MAX);
    cnt_d  = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pipe_recov_ctrl.sv
module pipe_recov_ctrl #(
  parameter int NUM_STAGES = 3,
  parameter int CNT_W      = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_STAGES-1:0] err_i,
  output logic                  adv_en_o,
  output logic                  restore_o,
  output logic [CNT_W-1:0]      stall_cnt_o
);
  logic rst_sync_n;
  logic any_err;
  logic restore;
  logic start;

  recov_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  recov_err_merge #(.NUM_STAGES(NUM_STAGES)) u_merge (
    .err_i     (err_i),
    .any_err_o (any_err)
  );

  recov_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .any_err_i (any_err),
    .restore_o (restore),
    .start_o   (start)
  );

  recov_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .inc_i (start),
    .cnt_o (stall_cnt_o)
  );

  assign restore_o = restore;
  assign adv_en_o  = ~restore;
endmodule

// File: rtl/pipe_recov_chk.sv
module pipe_recov_chk #(
  parameter int NUM_STAGES = 3,
  parameter int CNT_W      = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_STAGES-1:0] err_i,
  input logic                  adv_en_o,
  input logic                  restore_o,
  input logic [CNT_W-1:0]      stall_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R2
  err_starts_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|err_i) && !restore_o) |=> restore_o);

  // R3
  single_cycle_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore_o |=> !restore_o);

  // R4
  ignore_in_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore_o |=> $stable(stall_cnt_o));

  // R6
  count_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restore_o) |-> ((stall_cnt_o == $past(stall_cnt_o) + CNT_W'(1)) ||
                          ($past(stall_cnt_o) == CNT_MAX)));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_cnt_o == CNT_MAX) |=> (stall_cnt_o == CNT_MAX));

  // R9
  enable_vs_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en_o != restore_o);

  // R10
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|err_i) && !restore_o) |=> (adv_en_o && $stable(stall_cnt_o)));
endmodule

bind pipe_recov_ctrl pipe_recov_chk #(.NUM_STAGES(NUM_STAGES), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .err_i       (err_i),
  .adv_en_o    (adv_en_o),
  .restore_o   (restore_o),
  .stall_cnt_o (stall_cnt_o)
);

// File: tb/tb_pipe_recov_ctrl.sv
`timescale 1ns/1ps
module tb_pipe_recov_ctrl;
  localparam int NS = 3;
  localparam int CW = 8;
  localparam int NV = 13;

  logic          clk;
  logic          rst_n;
  logic [NS-1:0] err_i;
  logic          adv_en_o;
  logic          restore_o;
  logic [CW-1:0] stall_cnt_o;

  int n_chk;
  int n_fail;

  // {err[2:0], expected restore, expected count[7:0]}
  localparam logic [11:0] VEC [NV] = '{
    {3'b000, 1'b0, 8'd0},   // R10 idle
    {3'b001, 1'b1, 8'd1},   // R2 stage 0
    {3'b000, 1'b0, 8'd1},   // R3
    {3'b100, 1'b1, 8'd2},   // R2 stage 2
    {3'b010, 1'b0, 8'd2},   // R4 ignored
    {3'b000, 1'b0, 8'd2},   // R10
    {3'b111, 1'b1, 8'd3},   // R8
    {3'b111, 1'b0, 8'd3},   // R4 / R5
    {3'b111, 1'b1, 8'd4},   // R5
    {3'b111, 1'b0, 8'd4},   // R5
    {3'b000, 1'b0, 8'd4},   // R10
    {3'b010, 1'b1, 8'd5},   // R2 stage 1 / R6
    {3'b000, 1'b0, 8'd5}    // R3
  };

  pipe_recov_ctrl #(.NUM_STAGES(NS), .CNT_W(CW)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_i       (err_i),
    .adv_en_o    (adv_en_o),
    .restore_o   (restore_o),
    .stall_cnt_o (stall_cnt_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [NS-1:0] e);
    @(negedge clk);
    err_i = e;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    err_i = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int en_cnt;
    n_chk  = 0;
    n_fail = 0;
    err_i  = '0;
    rst_n  = 1'b0;
    do_reset();

    check("R1 adv_en", int'(adv_en_o), 1);
    check("R1 restore", int'(restore_o), 0);
    check("R1 count", int'(stall_cnt_o), 0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][11:9]);
      check("R2/R3/R4 restore", int'(restore_o), int'(VEC[i][8]));
      check("R9 adv_en", int'(adv_en_o), int'(!VEC[i][8]));
      check("R6/R8 count", int'(stall_cnt_o), int'(VEC[i][7:0]));
    end

    // R5: errors on every cycle give half-rate advance
    en_cnt = 0;
    for (int i = 0; i < 20; i++) begin
      step(3'b001);
      if (adv_en_o) en_cnt++;
    end
    check("R5 enables in 20 cycles", en_cnt, 10);
    step(3'b000);

    // R1: reset in the middle of a run
    step(3'b100);
    do_reset();
    check("R1 mid-run restore", int'(restore_o), 0);
    check("R1 mid-run count", int'(stall_cnt_o), 0);

    // R7: drive 300 recoveries, count saturates at 255
    for (int i = 0; i < 300; i++) begin
      step(3'b010);
      step(3'b000);
    end
    check("R7 saturated", int'(stall_cnt_o), 255);
    step(3'b001);
    check("R7 restore after saturation", int'(restore_o), 1);
    check("R7 held at max", int'(stall_cnt_o), 255);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule